// File: doc/BRIEF.md
# ISP Ready/Busy and Sticky Error Flag Unit

This block drives two status flags out to device pins while the part is being programmed in-system over a four-wire JTAG port. One flag shows whether the nonvolatile memory is idle (high) or busy (low). The other is an active-low error flag that latches when a flash operation fails and stays latched until software or a reset sequence releases it. A test host can poll these pins directly instead of shifting status words out through the scan chain.

The flags come alive only after the TAP controller decodes a programming-enable instruction. At that moment the unit also captures whether the pins should behave as push-pull or as open-drain. In open-drain mode several chained devices can share one wired line for each flag. The unit takes decoded one-cycle instruction strobes from the TAP and per-bank busy and fail events from the memory controller. It returns a data value and an output-enable for each pin. The pad cells themselves sit outside the block.

Top module: `isp_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises, both output-enables are 0 and the error flag is clear. An asynchronous reset during a session ends the session.
- R2: One clock edge after an `instr_enable` strobe, with push-pull selected, `rdy_oe` and `err_oe` are both 1. `rdy_o` shows the ready level and `err_o` shows the inverted error flag.
- R3: The ready level is registered. One edge after any `flash_busy` bit or `eeprom_busy` is 1 it reads 0. One edge after all of them are 0 it reads 1.
- R4: A single-cycle pulse on any `flash_fail` bit during an enabled session sets the error flag, and `err_o` reads 0 after that edge.
- R5: EEPROM write activity never sets the error flag.
- R6: The error flag holds after the fail input drops. It also holds through a `chip_rst` pulse that was not preceded by a disable instruction.
- R7: An `instr_clear` strobe clears the error flag at the next edge. When a fail event arrives in the same cycle as the clear, the set wins.
- R8: An `instr_disable` strobe drops both output-enables. A later `chip_rst` pulse clears the error flag, and this can be seen once the next enable is given.
- R9: The open-drain choice `od_sel` is captured only on `instr_enable`. In open-drain mode each pin's data is 0, and its output-enable is 1 only while the flag's level is low. Changing `od_sel` between enables has no effect.
- R10: A `flash_fail` pulse outside an enabled session is ignored.
- R11: When `instr_enable` and `instr_disable` strobe in the same cycle, the disable wins and the outputs stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| instr_enable | input | 1 | Decoded programming-enable instruction strobe |
| instr_disable | input | 1 | Decoded programming-disable instruction strobe |
| instr_clear | input | 1 | Decoded error-clear instruction strobe |
| chip_rst | input | 1 | Synchronous chip reset pulse |
| od_sel | input | 1 | Open-drain select, captured on enable |
| flash_busy | input | N_BANKS | Per-bank flash program/erase in progress |
| eeprom_busy | input | 1 | EEPROM write in progress |
| flash_fail | input | N_BANKS | Per-bank flash failure event |
| rdy_o | output | 1 | Ready/busy pin data |
| rdy_oe | output | 1 | Ready/busy pin output-enable |
| err_o | output | 1 | Error pin data (active low) |
| err_oe | output | 1 | Error pin output-enable |

## Verification
The bench goes after the release paths of the sticky flag. A design that clears the flag on any `chip_rst` would lose the error that the table expects to survive. A design that lets a clear beat a fail in the same cycle would drop a real failure. The bench also changes `od_sel` in the middle of a session. A design that reads the select bit live instead of latching it would start driving the pins in push-pull. Other cases probed are a fail while the unit is idle and a simultaneous enable with disable. Under those, a faulty design would latch a spurious error or leave the pins driven.

// File: rtl/isp_flag_pkg.sv
package isp_flag_pkg;

  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PIN_RDY  = 0;
  localparam int unsigned PIN_ERR  = 1;

  typedef struct packed {
    logic o;
    logic oe;
  } pin_drive_t;

  // Pin drive from a flag level: push-pull follows the level,
  // open-drain pulls low only when the level is low.
  function automatic pin_drive_t drive_pin(input logic level,
                                           input logic od,
                                           input logic en);
    pin_drive_t d;
    if (od) begin
      d.o  = 1'b0;
      d.oe = en & ~level;
    end else begin
      d.o  = level;
      d.oe = en;
    end
    return d;
  endfunction

endpackage

// File: rtl/isp_session_ctl.sv
module isp_session_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_enable,
  input  logic instr_disable,
  input  logic chip_rst,
  input  logic od_sel,
  output logic session_on,
  output logic od_mode,
  output logic disarmed
);

  logic enable_take;
  assign enable_take = instr_enable & ~instr_disable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      session_on <= 1'b0;
      od_mode    <= 1'b0;
      disarmed   <= 1'b0;
    end else if (instr_disable) begin
      session_on <= 1'b0;
      disarmed   <= 1'b1;
    end else if (enable_take) begin
      session_on <= 1'b1;
      od_mode    <= od_sel;
      disarmed   <= 1'b0;
    end else if (chip_rst) begin
      disarmed   <= 1'b0;
    end
  end

  // od_mode only moves on an accepted enable
  assert_od_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_take |=> $stable(od_mode));

  // same-cycle enable and disable leaves the session off
  assert_disable_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    instr_disable |=> !session_on);

endmodule

// File: rtl/isp_err_latch.sv
module isp_err_latch #(
  parameter int unsigned N_BANKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               session_on,
  input  logic               disarmed,
  input  logic               chip_rst,
  input  logic               instr_clear,
  input  logic [N_BANKS-1:0] flash_fail,
  output logic               err_flag,
  output logic               fail_evt,
  output logic               release_evt
);

  assign fail_evt    = session_on & (|flash_fail);
  assign release_evt = instr_clear | (chip_rst & disarmed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err_flag <= 1'b0;
    else if (fail_evt)    err_flag <= 1'b1;
    else if (release_evt) err_flag <= 1'b0;
  end

  assert_fail_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (session_on && (|flash_fail)) |=> err_flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !instr_clear && !(chip_rst && disarmed)) |=> err_flag);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_clear && !fail_evt) |=> !err_flag);

  assert_disarm_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst && disarmed && !fail_evt) |=> !err_flag);

  assert_idle_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!session_on && !err_flag) |=> !err_flag);

endmodule

// File: rtl/isp_busy_track.sv
module isp_busy_track #(
  parameter int unsigned N_BANKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_BANKS-1:0] flash_busy,
  input  logic               eeprom_busy,
  output logic               ready_lvl
);

  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= (|flash_busy) | eeprom_busy;
  end

  assign ready_lvl = ~busy_q;

  assert_busy_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flash_busy) || eeprom_busy) |=> !ready_lvl);

endmodule

// File: rtl/isp_flag_unit.sv
module isp_flag_unit
  import isp_flag_pkg::*;
#(
  parameter int unsigned N_BANKS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_enable,
  input  logic               instr_disable,
  input  logic               instr_clear,
  input  logic               chip_rst,
  input  logic               od_sel,
  input  logic [N_BANKS-1:0] flash_busy,
  input  logic               eeprom_busy,
  input  logic [N_BANKS-1:0] flash_fail,
  output logic               rdy_o,
  output logic               rdy_oe,
  output logic               err_o,
  output logic               err_oe
);

  logic session_on, od_mode, disarmed;
  logic err_flag, fail_evt, release_evt;
  logic ready_lvl;

  isp_session_ctl u_session (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_enable  (instr_enable),
    .instr_disable (instr_disable),
    .chip_rst      (chip_rst),
    .od_sel        (od_sel),
    .session_on    (session_on),
    .od_mode       (od_mode),
    .disarmed      (disarmed)
  );

  isp_err_latch #(.N_BANKS(N_BANKS)) u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .session_on  (session_on),
    .disarmed    (disarmed),
    .chip_rst    (chip_rst),
    .instr_clear (instr_clear),
    .flash_fail  (flash_fail),
    .err_flag    (err_flag),
    .fail_evt    (fail_evt),
    .release_evt (release_evt)
  );

  isp_busy_track #(.N_BANKS(N_BANKS)) u_busy (
    .clk         (clk),
    .rst_n       (rst_n),
    .flash_busy  (flash_busy),
    .eeprom_busy (eeprom_busy),
    .ready_lvl   (ready_lvl)
  );

  logic [NUM_PINS-1:0] flag_lvl;
  pin_drive_t          pin_drv [NUM_PINS];

  assign flag_lvl[PIN_RDY] = ready_lvl;
  assign flag_lvl[PIN_ERR] = ~err_flag;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_drv[p] = drive_pin(flag_lvl[p], od_mode, session_on);
  end

  assign rdy_o  = pin_drv[PIN_RDY].o;
  assign rdy_oe = pin_drv[PIN_RDY].oe;
  assign err_o  = pin_drv[PIN_ERR].o;
  assign err_oe = pin_drv[PIN_ERR].oe;

  assert_released_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !session_on |-> (!rdy_oe && !err_oe));

  assert_od_lowonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |-> (!rdy_o && !err_o));

  assert_clear_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (release_evt && !fail_evt && session_on && !instr_disable && !od_mode) |=>
      (err_o || !err_oe));

endmodule

// File: tb/isp_flag_unit_test.sv
module isp_flag_unit_test;

  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_enable = 0, instr_disable = 0, instr_clear = 0, chip_rst = 0, od_sel = 0;
  logic [NB-1:0] flash_busy = '0, flash_fail = '0;
  logic eeprom_busy = 0;
  logic rdy_o, rdy_oe, err_o, err_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  isp_flag_unit #(.N_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n),
    .instr_enable(instr_enable), .instr_disable(instr_disable),
    .instr_clear(instr_clear), .chip_rst(chip_rst), .od_sel(od_sel),
    .flash_busy(flash_busy), .eeprom_busy(eeprom_busy), .flash_fail(flash_fail),
    .rdy_o(rdy_o), .rdy_oe(rdy_oe), .err_o(err_o), .err_oe(err_oe)
  );

  // row: {en,dis,clr,crst,od, fbusy[1:0], ebusy, ffail[1:0], rdy_o,rdy_oe,err_o,err_oe}
  localparam int NROWS = 22;
  localparam logic [13:0] VEC [NROWS] = '{
    14'b00000_00_0_00_1010, // 0  idle, not enabled
    14'b10000_00_0_00_1111, // 1  enable push-pull
    14'b00000_01_0_00_0111, // 2  flash busy
    14'b00000_00_1_00_0111, // 3  eeprom busy, no error
    14'b00000_00_0_00_1111, // 4  idle
    14'b00000_00_0_01_1101, // 5  fail pulse
    14'b00000_00_0_00_1101, // 6  sticky
    14'b00010_00_0_00_1101, // 7  chip reset, not disarmed
    14'b00100_00_0_00_1111, // 8  clear
    14'b00100_00_0_10_1101, // 9  clear + fail, set wins
    14'b01000_00_0_00_1000, // 10 disable
    14'b00010_00_0_00_1010, // 11 chip reset after disable
    14'b10001_00_0_00_0000, // 12 enable open-drain
    14'b00000_10_0_00_0100, // 13 busy, od_sel changed to 0
    14'b00000_00_0_01_0001, // 14 fail in od mode
    14'b10000_00_0_00_1101, // 15 re-enable push-pull, error kept
    14'b01000_00_0_00_1000, // 16 disable
    14'b00010_00_0_00_1010, // 17 chip reset clears
    14'b00000_00_0_11_1010, // 18 fail while idle
    14'b10000_00_0_00_1111, // 19 enable: error clear
    14'b11000_00_0_00_1010, // 20 enable+disable together
    14'b00000_00_0_00_1010  // 21 still released
  };

  function automatic string row_req(int i);
    case (i)
      0:  return "R1";
      1:  return "R2";
      2:  return "R3";
      3:  return "R5";
      4:  return "R3";
      5:  return "R4";
      6:  return "R6";
      7:  return "R6";
      8:  return "R7";
      9:  return "R7";
      10: return "R8";
      11: return "R8";
      12: return "R9";
      13: return "R9";
      14: return "R9";
      15: return "R6";
      16: return "R8";
      17: return "R8";
      18: return "R10";
      19: return "R10";
      20: return "R11";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {rdy_o,rdy_oe,err_o,err_oe} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] s);
    @(negedge clk);
    {instr_enable, instr_disable, instr_clear, chip_rst, od_sel,
     flash_busy, eeprom_busy, flash_fail} = s;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] pins();
    return {rdy_o, rdy_oe, err_o, err_oe};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", pins(), 4'b1010);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      drive(VEC[i][13:4]);
      check(row_req(i), pins(), VEC[i][3:0]);
    end

    // R4: fail on upper bank in single cycle, then R1 async reset mid-session
    drive(10'b10000_00_0_00);
    drive(10'b00000_00_0_10);
    drive(10'b00000_00_0_00);
    check("R4 bank1", pins(), 4'b1101);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 async", pins(), 4'b1010);
    @(negedge clk) rst_n = 1'b1;
    drive(10'b10000_00_0_00);
    check("R1 flag cleared", pins(), 4'b1111);

    // R3: both busy sources at once, then release
    drive(10'b00000_11_1_00);
    check("R3 all busy", pins(), 4'b0111);
    drive(10'b00000_00_0_00);
    check("R3 release", pins(), 4'b1111);

    // R9: open-drain error pin with busy idle
    drive(10'b10001_00_0_00);
    check("R9 od idle", pins(), 4'b0000);
    drive(10'b00000_00_0_01);
    check("R9 od err", pins(), 4'b0001);
    drive(10'b00100_00_0_00);
    check("R7 od clear", pins(), 4'b0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule